// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block turns one host request at a time into a single access on an external asynchronous SRAM, PSRAM or NOR device. Each access walks through programmed phases: an address setup phase, an address hold phase (present only when address and data share the data lines), a data phase in which the strobe is active, and a tail in which chip select is released while write data stays on the bus. The phase lengths come from a per-bank timing word. When a bank runs in split-timing mode, its writes use a second timing word. Otherwise reads and writes share the first word.

The host side is a valid/ready request channel. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a host holding `req_valid` is stalled for the length of the current access. The result comes back on `rsp_valid` as a one-cycle pulse with no back-pressure: the host must be able to take it in the cycle it appears. Bank configuration is written through a small configuration port.

Configuration word encodings. The control word is in `cfg_data[7:0]`:
- bit0: bank enable
- bit1: multiplexed address/data
- bits[3:2]: memory type (0 SRAM, 1 PSRAM, 2 NOR)
- bits[5:4]: bus width (0 = 8-bit, non-zero = full width)
- bit6: write permit
- bit7: split timing

A timing word is in `cfg_data[19:0]`:
- setup [3:0]
- hold [7:4]
- data [15:8]
- access mode [17:16] (1 = early output enable, other values = late)
- tail [19:18]

`cfg_sel` selects the target: 0 = control word, 1 = read/main timing word, 2 = write timing word, 3 = no effect.

Top module: `smc_seq`

## Requirements
- R1: After reset, bank 0 holds control word 0x51 (enabled, writes permitted, SRAM, full width) and every other bank holds 0 (disabled). All timing words are 0, `req_ready` is 1, all chip selects and strobes are high, and `rsp_valid` is 0.
- R2: A request is taken when `req_valid` and `req_ready` are high at a clock edge. `req_ready` is 0 while an access is in progress. Each taken request produces exactly one single-cycle `rsp_valid` pulse.
- R3: Only the addressed bank's chip select is driven low, and it stays low for exactly S+H+D cycles. D equals the data count plus 1. It is followed by `tail` cycles with chip select high. `rsp_valid` rises in the cycle after the last of these phases.
- R4: On a read, `rsp_rdata` carries the value of `mem_dq_in` sampled in the last cycle of the data phase.
- R5: On a write, `mem_we_n` is low for exactly the D data-phase cycles. `mem_dq_out` carries the write data with `mem_dq_oe` high during the data phase and the tail.
- R6: With split timing off, reads and writes both use timing word 1. With split timing on, writes use timing word 2 and reads keep using timing word 1.
- R7: In multiplexed mode, the setup length is max(setup,1) and a hold phase of max(hold,1) cycles follows it. `mem_adv_n` is low for the setup phase. The low DW address bits are driven on `mem_dq_out` during setup and hold. Without multiplexing, the hold phase is absent.
- R8: Output enable is low only during the read data phase (late mode), or for the whole read access (early mode). With split timing off, NOR uses early mode and SRAM/PSRAM use late mode. With split timing on, the access-mode field selects the mode. Early mode is not applied in multiplexed mode.
- R9: A request to a disabled bank drives no chip select and answers with `rsp_err`=1 in the first cycle after it is taken.
- R10: A write to a bank whose write permit is 0 performs no access and answers with `rsp_err`=1. Reads of that bank still succeed.
- R11: During an access on a full-width bank, `mem_be_n` equals the inverted byte enables. On an 8-bit bank it stays all ones.
- R12: A configuration write updates only the selected word of the selected bank, for example enabling a bank that was off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | BW | Bank addressed by configuration write |
| cfg_sel | input | 2 | Word select: 0 control, 1 main timing, 2 write timing |
| cfg_data | input | 20 | Configuration data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BW | Target bank |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | DW | Read data |
| mem_cs_n | output | NBANK | Per-bank chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address latch strobe, active low |
| mem_be_n | output | DW/8 | Byte-lane strobes, active low |
| mem_addr | output | AW | Address lines |
| mem_dq_out | output | DW | Data lines, outbound |
| mem_dq_oe | output | 1 | Data line drive enable |
| mem_dq_in | input | DW | Data lines, inbound |

## Verification
A phase counter that is off by one shows up at once as chip select, a strobe or the address latch staying low for one cycle too many or too few. It also moves the response pulse by one cycle in the same access, so every scenario counts strobe-low cycles and response latency. A wrong capture point shows as read data from a neighbouring data-phase cycle, because the bench changes `mem_dq_in` every cycle. A wrongly chosen timing word or mode shows as the wrong strobe length in the first access after the configuration change. A bank or permit check that fails shows as a strobe on a refused access, or as a missing error flag on the very next response.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef struct packed {
    logic       split;
    logic       wr_permit;
    logic [1:0] width;
    logic [1:0] mtype;
    logic       mux;
    logic       en;
  } bank_ctrl_t;

  typedef struct packed {
    logic [1:0] tail;
    logic [1:0] amode;
    logic [7:0] data;
    logic [3:0] hold;
    logic [3:0] setup;
  } bank_tim_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_HOLD, PH_DATA, PH_TAIL, PH_RESP
  } phase_t;

  localparam int unsigned CFGW = $bits(bank_tim_t);
  localparam logic [1:0] MT_NOR = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_RTIM = 2'd1;
  localparam logic [1:0] SEL_WTIM = 2'd2;
  localparam bank_ctrl_t CTRL_BANK0_RST = 8'h51;
endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int unsigned NBANK = 4,
  localparam int unsigned BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [BW-1:0]    cfg_bank,
  input  logic [1:0]       cfg_sel,
  input  logic [CFGW-1:0]  cfg_data,
  output bank_ctrl_t       ctrl_q [NBANK],
  output bank_tim_t        rtim_q [NBANK],
  output bank_tim_t        wtim_q [NBANK]
);
  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic hit;
    assign hit = cfg_we && (cfg_bank == BW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[i] <= (i == 0) ? CTRL_BANK0_RST : '0;
        rtim_q[i] <= '0;
        wtim_q[i] <= '0;
      end else if (hit) begin
        if (cfg_sel == SEL_CTRL) ctrl_q[i] <= bank_ctrl_t'(cfg_data[$bits(bank_ctrl_t)-1:0]);
        if (cfg_sel == SEL_RTIM) rtim_q[i] <= bank_tim_t'(cfg_data);
        if (cfg_sel == SEL_WTIM) wtim_q[i] <= bank_tim_t'(cfg_data);
      end
    end
  end
endmodule

// File: rtl/smc_phase.sv
module smc_phase
  import smc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_err,
  input  bank_tim_t  tim,
  input  logic       mux,
  output phase_t     phase,
  output logic       last
);
  logic [3:0] s_q, h_q, s_e, h_e;
  logic [7:0] d_q;
  logic [1:0] t_q;
  logic [8:0] cnt;

  function automatic phase_t after(phase_t p, logic [3:0] s, logic [3:0] h, logic [1:0] t);
    case (p)
      PH_IDLE:  return (s != 0) ? PH_SETUP : ((h != 0) ? PH_HOLD : PH_DATA);
      PH_SETUP: return (h != 0) ? PH_HOLD : PH_DATA;
      PH_HOLD:  return PH_DATA;
      PH_DATA:  return (t != 0) ? PH_TAIL : PH_RESP;
      PH_TAIL:  return PH_RESP;
      default:  return PH_IDLE;
    endcase
  endfunction

  function automatic logic [8:0] len_of(phase_t p, logic [3:0] s, logic [3:0] h,
                                        logic [7:0] d, logic [1:0] t);
    case (p)
      PH_SETUP: return {5'd0, s};
      PH_HOLD:  return {5'd0, h};
      PH_DATA:  return {1'b0, d} + 9'd1;
      PH_TAIL:  return {7'd0, t};
      default:  return 9'd1;
    endcase
  endfunction

  // multiplexed bus forces a non-empty setup and hold
  assign s_e = (mux && tim.setup == 4'd0) ? 4'd1 : tim.setup;
  assign h_e = mux ? ((tim.hold == 4'd0) ? 4'd1 : tim.hold) : 4'd0;
  assign last = (cnt == 9'd0);

  phase_t nxt0, nxt;
  assign nxt0 = after(PH_IDLE, s_e, h_e, tim.tail);
  assign nxt  = after(phase, s_q, h_q, t_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      s_q   <= '0;
      h_q   <= '0;
      d_q   <= '0;
      t_q   <= '0;
    end else if (start) begin
      s_q <= s_e;
      h_q <= h_e;
      d_q <= tim.data;
      t_q <= tim.tail;
      if (start_err) begin
        phase <= PH_RESP;
        cnt   <= '0;
      end else begin
        phase <= nxt0;
        cnt   <= len_of(nxt0, s_e, h_e, tim.data, tim.tail) - 9'd1;
      end
    end else if (phase != PH_IDLE) begin
      if (last) begin
        phase <= nxt;
        cnt   <= len_of(nxt, s_q, h_q, d_q, t_q) - 9'd1;
      end else begin
        cnt <= cnt - 9'd1;
      end
    end
  end

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RESP) |=> (phase == PH_IDLE));
endmodule

// File: rtl/smc_seq.sv
module smc_seq
  import smc_pkg::*;
#(
  parameter int unsigned NBANK = 4,
  parameter int unsigned AW    = 20,
  parameter int unsigned DW    = 16,
  localparam int unsigned BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int unsigned NBE  = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [BW-1:0]     cfg_bank,
  input  logic [1:0]        cfg_sel,
  input  logic [CFGW-1:0]   cfg_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BW-1:0]     req_bank,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [NBE-1:0]    req_be,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata,
  output logic [NBANK-1:0]  mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [NBE-1:0]    mem_be_n,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_dq_in
);
  bank_ctrl_t ctrl_q [NBANK];
  bank_tim_t  rtim_q [NBANK];
  bank_tim_t  wtim_q [NBANK];

  smc_cfg_regs #(.NBANK(NBANK)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_bank, .cfg_sel, .cfg_data,
    .ctrl_q, .rtim_q, .wtim_q
  );

  bank_ctrl_t sel_ctrl;
  bank_tim_t  sel_tim;
  logic       accept, sel_err, sel_early;

  assign sel_ctrl  = ctrl_q[req_bank];
  assign sel_tim   = (sel_ctrl.split && req_write) ? wtim_q[req_bank] : rtim_q[req_bank];
  assign sel_err   = !sel_ctrl.en || (req_write && !sel_ctrl.wr_permit);
  assign sel_early = (sel_ctrl.split ? (sel_tim.amode == 2'd1) : (sel_ctrl.mtype == MT_NOR))
                     && !sel_ctrl.mux && !req_write;
  assign accept    = req_valid && req_ready;

  phase_t phase;
  logic   last;

  smc_phase u_phase (
    .clk, .rst_n, .start(accept), .start_err(sel_err),
    .tim(sel_tim), .mux(sel_ctrl.mux), .phase, .last
  );

  logic [BW-1:0]  a_bank;
  logic           a_write, a_mux, a_early, a_wide, a_err;
  logic [AW-1:0]  a_addr;
  logic [DW-1:0]  a_wdata, rdata_q;
  logic [NBE-1:0] a_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_bank <= '0; a_write <= 1'b0; a_mux <= 1'b0; a_early <= 1'b0;
      a_wide <= 1'b0; a_err <= 1'b0; a_addr <= '0; a_wdata <= '0;
      a_be <= '0; rdata_q <= '0;
    end else if (accept) begin
      a_bank  <= req_bank;
      a_write <= req_write;
      a_mux   <= sel_ctrl.mux;
      a_early <= sel_early;
      a_wide  <= (sel_ctrl.width != 2'd0);
      a_err   <= sel_err;
      a_addr  <= req_addr;
      a_wdata <= req_wdata;
      a_be    <= req_be;
      rdata_q <= '0;
    end else if (phase == PH_DATA && last && !a_write) begin
      rdata_q <= mem_dq_in;
    end
  end

  logic in_acc, addr_ph, wdat_ph;
  assign in_acc  = (phase == PH_SETUP) || (phase == PH_HOLD) || (phase == PH_DATA);
  assign addr_ph = a_mux && ((phase == PH_SETUP) || (phase == PH_HOLD));
  assign wdat_ph = a_write && ((phase == PH_DATA) || (phase == PH_TAIL));

  for (genvar i = 0; i < NBANK; i++) begin : g_cs
    assign mem_cs_n[i] = !(in_acc && a_bank == BW'(i));
  end

  assign req_ready  = (phase == PH_IDLE);
  assign rsp_valid  = (phase == PH_RESP);
  assign rsp_err    = a_err;
  assign rsp_rdata  = rdata_q;
  assign mem_oe_n   = !(!a_write && ((phase == PH_DATA) || (a_early && in_acc)));
  assign mem_we_n   = !(a_write && phase == PH_DATA);
  assign mem_adv_n  = !(a_mux && phase == PH_SETUP);
  assign mem_addr   = in_acc ? a_addr : '0;
  assign mem_be_n   = (in_acc && a_wide) ? ~a_be : '1;
  assign mem_dq_oe  = addr_ph || wdat_ph;
  assign mem_dq_out = addr_ph ? a_addr[DW-1:0] : (wdat_ph ? a_wdata : '0);

  // R5
  we_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !(&mem_cs_n));
  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R2
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_cs_n) |-> !req_ready);
  // R7
  adv_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (mem_dq_oe && mem_oe_n && mem_we_n));
  // R9
  err_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> $past(&mem_cs_n));
  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
endmodule

// File: tb/smc_seq_tb.sv
`timescale 1ns/1ps
module smc_seq_tb;
  localparam int NBANK = 4, AW = 20, DW = 16;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic cfg_we = 0; logic [1:0] cfg_bank = 0; logic [1:0] cfg_sel = 0; logic [19:0] cfg_data = 0;
  logic req_valid = 0, req_write = 0; logic [1:0] req_bank = 0;
  logic [AW-1:0] req_addr = 0; logic [DW-1:0] req_wdata = 0; logic [1:0] req_be = 0;
  logic req_ready, rsp_valid, rsp_err, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out; logic [DW-1:0] mem_dq_in = 0;
  logic [NBANK-1:0] mem_cs_n; logic [1:0] mem_be_n; logic [AW-1:0] mem_addr;

  smc_seq #(.NBANK(NBANK), .AW(AW), .DW(DW)) u_dut (.*);

  int checks = 0, errors = 0;
  int n_cyc, n_cs, n_oe, n_we, n_adv, dcnt;
  bit wbad, abad, rdybad, got_err;
  logic [DW-1:0] got_rdata; logic [1:0] be_seen; logic [NBANK-1:0] cs_seen;
  localparam logic [DW-1:0] BASE = 16'hA000;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mk_ctrl(bit en, bit mux, logic [1:0] mt, logic [1:0] w, bit wp, bit sp);
    return {12'd0, sp, wp, w, mt, mux, en};
  endfunction
  function automatic logic [19:0] mk_tim(logic [3:0] s, logic [3:0] h, logic [7:0] d, logic [1:0] m, logic [1:0] t);
    return {t, m, d, h, s};
  endfunction

  task automatic cfg(logic [1:0] b, logic [1:0] sel, logic [19:0] d);
    @(negedge clk); cfg_we = 1; cfg_bank = b; cfg_sel = sel; cfg_data = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic run(logic [1:0] b, bit wr, logic [AW-1:0] a, logic [DW-1:0] wd, logic [1:0] be);
    @(negedge clk);
    req_valid = 1; req_bank = b; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    dcnt = 0; mem_dq_in = BASE;
    @(posedge clk);
    @(negedge clk); req_valid = 0;
    n_cyc = 0; n_cs = 0; n_oe = 0; n_we = 0; n_adv = 0;
    wbad = 0; abad = 0; rdybad = 0; be_seen = 2'b11; cs_seen = '1;
    while (!rsp_valid && n_cyc < 1000) begin
      if (!(&mem_cs_n)) begin
        n_cs++; be_seen = mem_be_n; cs_seen = mem_cs_n;
        if (req_ready) rdybad = 1;
      end
      if (!mem_oe_n) begin dcnt++; n_oe++; mem_dq_in = BASE + DW'(dcnt); end
      if (!mem_we_n) begin n_we++; if (mem_dq_out != wd || !mem_dq_oe) wbad = 1; end
      if (!mem_adv_n) begin n_adv++; if (mem_dq_out != a[DW-1:0] || !mem_dq_oe) abad = 1; end
      n_cyc++;
      @(negedge clk);
    end
    got_err = rsp_err; got_rdata = rsp_rdata;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ready", int'(req_ready), 1);
    check("R1 cs_n", int'(mem_cs_n), 4'hF);
    check("R1 strobes", int'({mem_oe_n, mem_we_n, mem_adv_n}), 3'b111);
    check("R1 rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_default_read();
    run(0, 0, 20'h00123, 0, 2'b11);
    check("R1 bank0 ok", int'(got_err), 0);
    check("R3 cycles", n_cyc, 1);
    check("R4 rdata", int'(got_rdata), int'(BASE + 1));
  endtask

  task automatic t_timed_read_write();
    cfg(0, 1, mk_tim(3, 0, 4, 0, 2));
    run(0, 0, 20'h00456, 0, 2'b11);
    check("R3 cs cycles", n_cs, 8);
    check("R3 total cycles", n_cyc, 10);
    check("R8 late oe", n_oe, 5);
    check("R4 rdata", int'(got_rdata), int'(BASE + 5));
    check("R2 ready low", int'(rdybad), 0);
    run(0, 1, 20'h00456, 16'h5A5A, 2'b01);
    check("R6 shared word we", n_we, 5);
    check("R5 wdata", int'(wbad), 0);
    check("R11 be wide", int'(be_seen), 2'b10);
    check("R5 no oe on write", n_oe, 0);
  endtask

  task automatic t_split();
    cfg(0, 0, mk_ctrl(1, 0, 0, 1, 1, 1));
    cfg(0, 2, mk_tim(1, 0, 1, 0, 0));
    run(0, 1, 20'h00010, 16'h1234, 2'b11);
    check("R6 write word we", n_we, 2);
    check("R6 write word cs", n_cs, 3);
    run(0, 0, 20'h00010, 0, 2'b11);
    check("R6 read keeps main", n_cs, 8);
  endtask

  task automatic t_mux();
    cfg(0, 0, mk_ctrl(1, 1, 0, 1, 1, 0));
    cfg(0, 1, mk_tim(0, 0, 2, 0, 0));
    run(0, 0, 20'h0BEEF, 0, 2'b11);
    check("R7 adv cycles", n_adv, 1);
    check("R7 cs with hold", n_cs, 5);
    check("R7 address on dq", int'(abad), 0);
    check("R4 mux rdata", int'(got_rdata), int'(BASE + 3));
  endtask

  task automatic t_oe_modes();
    cfg(0, 0, mk_ctrl(1, 0, 2, 1, 1, 0));
    cfg(0, 1, mk_tim(2, 0, 1, 0, 0));
    run(0, 0, 20'h00020, 0, 2'b11);
    check("R8 nor early oe", n_oe, 4);
    cfg(0, 0, mk_ctrl(1, 0, 2, 1, 1, 1));
    run(0, 0, 20'h00020, 0, 2'b11);
    check("R8 split late oe", n_oe, 2);
    cfg(0, 1, mk_tim(2, 0, 1, 1, 0));
    cfg(0, 0, mk_ctrl(1, 0, 0, 1, 1, 1));
    run(0, 0, 20'h00020, 0, 2'b11);
    check("R8 split early oe", n_oe, 4);
  endtask

  task automatic t_errors();
    run(1, 0, 20'h00030, 0, 2'b11);
    check("R9 err", int'(got_err), 1);
    check("R9 no cs", n_cs, 0);
    check("R9 latency", n_cyc, 0);
    cfg(0, 0, mk_ctrl(1, 0, 0, 1, 0, 0));
    run(0, 1, 20'h00030, 16'hFFFF, 2'b11);
    check("R10 err", int'(got_err), 1);
    check("R10 no we", n_we, 0);
    run(0, 0, 20'h00030, 0, 2'b11);
    check("R10 read ok", int'(got_err), 0);
  endtask

  task automatic t_lanes_and_enable();
    cfg(0, 0, mk_ctrl(1, 0, 0, 0, 1, 0));
    run(0, 1, 20'h00040, 16'h00AA, 2'b01);
    check("R11 narrow be", int'(be_seen), 2'b11);
    cfg(2, 0, mk_ctrl(1, 0, 0, 1, 1, 0));
    run(2, 0, 20'h00050, 0, 2'b11);
    check("R12 bank2 ok", int'(got_err), 0);
    check("R12 bank2 cs", int'(cs_seen), 4'b1011);
    run(1, 0, 20'h00050, 0, 2'b11);
    check("R12 bank1 still off", int'(got_err), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default_read();
    t_timed_read_write();
    t_split();
    t_mux();
    t_oe_modes();
    t_errors();
    t_lanes_and_enable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule